// File: doc/BRIEF.md
# External Bus Access Phase Sequencer

This block times each access on an asynchronous parallel memory or peripheral bus. A requester asks for a read or a write to one of several zones. The sequencer then walks the access through three phases that never change order: lead, active, trail. Chip-select for the chosen zone stays low for the whole access. The read or write strobe is low only during the active phase. A one-cycle completion pulse marks the last cycle of the access.

Every zone has its own timing record. The record holds separate lead, active and trail counts for reads and for writes, plus a flag that tells the sequencer whether to honour the external ready input. One global flag doubles the programmed counts. When ready is honoured, a low ready on the last programmed active cycle adds wait cycles until ready is seen high. The sequencer does not check the programmed values for legality. It runs whatever counts are loaded. When a request is accepted, the sequencer takes a copy of the selected zone's record and of the doubling flag. Later configuration writes therefore affect only later accesses.

All logic runs on one timing clock with a synchronous active-low reset.

Top module: `xbus_phase_seq`

## Requirements
- R1: Phases run lead, then active, then trail. The chosen zone's chip-select is low from the first lead cycle through the last cycle of the access. The strobe is low only in the active phase, and the chip-select is never high while a strobe is low.
- R2: `req_zone` picks the timing record used and the single chip-select bit driven, `cs_n[req_zone]`. No other chip-select bit goes low.
- R3: A read (`req_wr`=0) uses the zone's read counts and pulses only `rd_n`. A write (`req_wr`=1) uses the write counts and pulses only `wr_n`. The two strobes are never low together.
- R4: With doubling clear, lead lasts LEAD cycles, active lasts ACTIVE+1+WS cycles and trail lasts TRAIL cycles.
- R5: With doubling set, lead lasts 2×LEAD cycles, active lasts 2×ACTIVE+1+WS cycles and trail lasts 2×TRAIL cycles. The +1 and WS are not doubled.
- R6: When the zone's `use_ready` bit is 1, `rdy` is sampled on the last programmed active cycle. Each low sample adds one active cycle, and the active phase ends on the first high sample.
- R7: When `use_ready` is 0, `rdy` has no effect and WS is 0.
- R8: A count of zero skips its phase. With zero trail, the access ends on its last active cycle. With zero lead, the strobe starts in the first cycle.
- R9: `done` is high for exactly one cycle per access, on its final cycle.
- R10: A request is accepted only while `busy` is 0. A request raised during an access is dropped and starts no access.
- R11: A configuration write to a zone during an access to that zone does not change that access. The next access uses the new values.
- R12: After reset every `cs_n` bit, `rd_n` and `wr_n` are 1, and `done` and `busy` are 0.
- R13: `cfg_wdata` packs, from MSB to LSB: `use_ready` (1 bit), then read lead, read active, read trail, write lead, write active and write trail, each 4 bits wide. `dbl_we` loads `dbl_in` as the doubling flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for one zone's timing record |
| cfg_zone | input | 2 | Zone written by `cfg_we` |
| cfg_wdata | input | 25 | Timing record, layout in R13 |
| dbl_we | input | 1 | Load strobe for the doubling flag |
| dbl_in | input | 1 | New doubling flag value |
| req | input | 1 | Access request, taken when idle |
| req_zone | input | 2 | Zone of the request |
| req_wr | input | 1 | 1 = write, 0 = read |
| rdy | input | 1 | External ready, active high |
| cs_n | output | 4 | Per-zone chip-selects, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-cycle pulse on the final access cycle |

## Verification
The bench measures each phase's length from the chip-select and strobe waveforms and targets the cases that are easy to get wrong:
- A design that doubled the whole active term would show too long an active phase in the doubled read and the doubled ready-wait access.
- A design that sampled ready with `use_ready` clear would stretch the access held with `rdy` low.
- A design that did not skip a zero trail, or that placed `done` after the last chip-select cycle, would show an extra cycle or a misplaced pulse.
- A design that read the live registers instead of a copy would change length when the same zone is reprogrammed mid-access.
- A design that took a request while busy would drive a second zone's chip-select.

// File: rtl/xbus_pkg.sv
// Package: shared types for the external bus phase sequencer.
// Assumes: one counter width serves every phase count of every zone.
package xbus_pkg;

    parameter int XB_CNT_W = 4;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LEAD  = 2'd1,
        PH_ACT   = 2'd2,
        PH_TRAIL = 2'd3
    } phase_t;

    typedef struct packed {
        logic [XB_CNT_W-1:0] lead;
        logic [XB_CNT_W-1:0] act;
        logic [XB_CNT_W-1:0] trail;
    } phase_cnt_t;

    typedef struct packed {
        logic       use_ready;
        phase_cnt_t rd;
        phase_cnt_t wr;
    } zone_cfg_t;

endpackage

// File: rtl/xbus_timing_regs.sv
// Module: per-zone timing record storage plus the global doubling flag.
// Assumes: one write per cycle; reads are combinational by zone index.
module xbus_timing_regs
    import xbus_pkg::*;
#(
    parameter int NUM_ZONES = 4,
    parameter int ZW        = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [ZW-1:0] cfg_zone,
    input  zone_cfg_t     cfg_wdata,
    input  logic          dbl_we,
    input  logic          dbl_in,
    input  logic [ZW-1:0] rd_zone,
    output zone_cfg_t     rd_cfg,
    output logic          dbl
);

    zone_cfg_t regs [NUM_ZONES];

    for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zone
        // Hold one zone's record; cleared on reset, loaded on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[z] <= '0;
            else if (cfg_we && cfg_zone == ZW'(z))
                regs[z] <= cfg_wdata;
        end
    end

    // Hold the global doubling flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dbl <= 1'b0;
        else if (dbl_we)
            dbl <= dbl_in;
    end

    // Present the record of the requested zone.
    always_comb rd_cfg = regs[rd_zone];

endmodule

// File: rtl/xbus_phase_fsm.sv
// Module: phase sequencer. Takes a copy of the counts when it accepts a
// request, then counts lead, active (with ready wait) and trail.
// Assumes: a zero count skips its phase; no legality check of counts.
module xbus_phase_fsm
    import xbus_pkg::*;
#(
    parameter int ZW    = 2,
    parameter int LEN_W = XB_CNT_W + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [ZW-1:0] req_zone,
    input  logic          req_wr,
    input  zone_cfg_t     sel_cfg,
    input  logic          dbl,
    input  logic          rdy,
    output phase_t        phase,
    output logic [ZW-1:0] zone_q,
    output logic          wr_q,
    output logic          busy,
    output logic          done
);

    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    logic [LEN_W-1:0] cnt, act_len_q, trail_len_q;
    logic [LEN_W-1:0] lead_len, act_len, trail_len;
    logic             use_rdy_q, hold, accept;
    phase_cnt_t       pick;

    function automatic logic [LEN_W-1:0] scale(input logic [XB_CNT_W-1:0] c,
                                               input logic d);
        return d ? {c, 1'b0} : {1'b0, c};
    endfunction

    // Work out the lengths of the phases for the incoming request.
    always_comb begin
        pick      = req_wr ? sel_cfg.wr : sel_cfg.rd;
        lead_len  = scale(pick.lead, dbl);
        act_len   = scale(pick.act, dbl) + ONE;
        trail_len = scale(pick.trail, dbl);
    end

    assign busy   = (phase != PH_IDLE);
    assign accept = (phase == PH_IDLE) && req;
    assign hold   = (phase == PH_ACT) && (cnt == '0) && use_rdy_q && !rdy;
    assign done   = ((phase == PH_ACT) && (cnt == '0) && !hold && (trail_len_q == '0))
                 || ((phase == PH_TRAIL) && (cnt == '0));

    // Take the request's settings on acceptance; they stay fixed for the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zone_q      <= '0;
            wr_q        <= 1'b0;
            use_rdy_q   <= 1'b0;
            act_len_q   <= '0;
            trail_len_q <= '0;
        end else if (accept) begin
            zone_q      <= req_zone;
            wr_q        <= req_wr;
            use_rdy_q   <= sel_cfg.use_ready;
            act_len_q   <= act_len;
            trail_len_q <= trail_len;
        end
    end

    // Step through the phases and their cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: if (accept) begin
                    if (lead_len != '0) begin
                        phase <= PH_LEAD;
                        cnt   <= lead_len - ONE;
                    end else begin
                        phase <= PH_ACT;
                        cnt   <= act_len - ONE;
                    end
                end
                PH_LEAD: if (cnt == '0) begin
                    phase <= PH_ACT;
                    cnt   <= act_len_q - ONE;
                end else begin
                    cnt <= cnt - ONE;
                end
                PH_ACT: if (cnt != '0) begin
                    cnt <= cnt - ONE;
                end else if (!hold) begin
                    if (trail_len_q != '0) begin
                        phase <= PH_TRAIL;
                        cnt   <= trail_len_q - ONE;
                    end else begin
                        phase <= PH_IDLE;
                    end
                end
                PH_TRAIL: if (cnt == '0) phase <= PH_IDLE;
                          else           cnt   <= cnt - ONE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_READY_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ACT && cnt == '0 && use_rdy_q && !rdy) |=> (phase == PH_ACT)); // R6
    AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req) |=> $stable(zone_q)); // R10
    AST_LEAD_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LEAD) |=> (phase == PH_LEAD || phase == PH_ACT)); // R1
    AST_TRAIL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_TRAIL) |=> (phase == PH_TRAIL || phase == PH_IDLE)); // R1
    AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (phase == PH_IDLE)); // R9

endmodule

// File: rtl/xbus_strobe_drv.sv
// Module: turns the current phase into active-low chip-selects and strobes.
// Assumes: the phase, zone and direction inputs come straight from registers.
module xbus_strobe_drv
    import xbus_pkg::*;
#(
    parameter int NUM_ZONES = 4,
    parameter int ZW        = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  phase_t               phase,
    input  logic [ZW-1:0]        zone_q,
    input  logic                 wr_q,
    output logic [NUM_ZONES-1:0] cs_n,
    output logic                 rd_n,
    output logic                 wr_n
);

    for (genvar z = 0; z < NUM_ZONES; z++) begin : g_cs
        // Pull a zone's select low for every non-idle cycle of its access.
        always_comb cs_n[z] = !((phase != PH_IDLE) && (zone_q == ZW'(z)));
    end

    // Pull the direction's strobe low during the active phase only.
    always_comb begin
        rd_n = !((phase == PH_ACT) && !wr_q);
        wr_n = !((phase == PH_ACT) && wr_q);
    end

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n)); // R2
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n)); // R3
    AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> (cs_n != '1)); // R1

endmodule

// File: rtl/xbus_phase_seq.sv
// Module: top of the external bus access phase sequencer.
// Assumes: all inputs synchronous to clk; ready is synchronised upstream.
module xbus_phase_seq
    import xbus_pkg::*;
#(
    parameter int NUM_ZONES = 4,
    parameter int ZW        = (NUM_ZONES > 1) ? $clog2(NUM_ZONES) : 1,
    parameter int CFG_W     = 6 * XB_CNT_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [ZW-1:0]        cfg_zone,
    input  logic [CFG_W-1:0]     cfg_wdata,
    input  logic                 dbl_we,
    input  logic                 dbl_in,
    input  logic                 req,
    input  logic [ZW-1:0]        req_zone,
    input  logic                 req_wr,
    input  logic                 rdy,
    output logic [NUM_ZONES-1:0] cs_n,
    output logic                 rd_n,
    output logic                 wr_n,
    output logic                 busy,
    output logic                 done
);

    zone_cfg_t     sel_cfg;
    logic          dbl, wr_q;
    logic [ZW-1:0] zone_q;
    phase_t        phase;

    xbus_timing_regs #(.NUM_ZONES(NUM_ZONES), .ZW(ZW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_zone(cfg_zone), .cfg_wdata(zone_cfg_t'(cfg_wdata)),
        .dbl_we(dbl_we), .dbl_in(dbl_in),
        .rd_zone(req_zone), .rd_cfg(sel_cfg), .dbl(dbl)
    );

    xbus_phase_fsm #(.ZW(ZW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req(req), .req_zone(req_zone), .req_wr(req_wr),
        .sel_cfg(sel_cfg), .dbl(dbl), .rdy(rdy),
        .phase(phase), .zone_q(zone_q), .wr_q(wr_q),
        .busy(busy), .done(done)
    );

    xbus_strobe_drv #(.NUM_ZONES(NUM_ZONES), .ZW(ZW)) u_drv (
        .clk(clk), .rst_n(rst_n),
        .phase(phase), .zone_q(zone_q), .wr_q(wr_q),
        .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n)
    );

endmodule

// File: tb/xbus_phase_seq_test.sv
// Bench: directed scenarios, one task each. Phase lengths are measured
// from chip-select and strobe waveforms sampled on the falling edge.
module xbus_phase_seq_test;
    import xbus_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NZ = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_we = 1'b0, dbl_we = 1'b0, dbl_in = 1'b0;
    logic [1:0]     cfg_zone = '0, req_zone = '0;
    logic [24:0]    cfg_wdata = '0;
    logic           req = 1'b0, req_wr = 1'b0, rdy = 1'b1;
    logic [NZ-1:0]  cs_n;
    logic           rd_n, wr_n, busy, done;

    int checks = 0, errors = 0;
    zone_cfg_t shadow [NZ];
    bit dbl_m = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbus_phase_seq uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_zone(cfg_zone),
        .cfg_wdata(cfg_wdata), .dbl_we(dbl_we), .dbl_in(dbl_in),
        .req(req), .req_zone(req_zone), .req_wr(req_wr), .rdy(rdy),
        .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic zone_cfg_t mk(input bit ur, input int rl, ra, rt, wl, wa, wt);
        zone_cfg_t c;
        c.use_ready = ur;
        c.rd.lead = 4'(rl); c.rd.act = 4'(ra); c.rd.trail = 4'(rt);
        c.wr.lead = 4'(wl); c.wr.act = 4'(wa); c.wr.trail = 4'(wt);
        return c;
    endfunction

    task automatic write_cfg(input int z, input zone_cfg_t c);
        @(negedge clk);
        cfg_we = 1'b1; cfg_zone = 2'(z); cfg_wdata = c;
        @(negedge clk);
        cfg_we = 1'b0;
        shadow[z] = c;
    endtask

    task automatic set_dbl(input bit d);
        @(negedge clk);
        dbl_we = 1'b1; dbl_in = d;
        @(negedge clk);
        dbl_we = 1'b0;
        dbl_m = d;
    endtask

    // One access, measured and checked. ws: cycles ready is held low at the
    // last programmed active cycle. mid_cfg: reprogram zone z mid-access.
    // poke: raise a request to another zone during the lead phase.
    task automatic run_access(input int z, input bit wr, input int ws,
                              input string tag, input bit mid_cfg,
                              input zone_cfg_t newc, input bit poke);
        phase_cnt_t pc;
        int mul, eL, eA, eT, progA;
        int nL = 0, nA = 0, nT = 0, nDone = 0, idx = 0, doneIdx = -1, lastCs = -1;
        bit foreign = 0, wrong = 0, started = 0, cfg_pulse = 0, poked = 0;
        pc  = wr ? shadow[z].wr : shadow[z].rd;
        mul = dbl_m ? 2 : 1;
        eL  = mul * int'(pc.lead);
        progA = mul * int'(pc.act) + 1;
        eA  = progA + (shadow[z].use_ready ? ws : 0);
        eT  = mul * int'(pc.trail);
        @(negedge clk);
        req = 1'b1; req_zone = 2'(z); req_wr = wr; rdy = (ws == 0);
        for (int cyc = 0; cyc < 300; cyc++) begin
            @(negedge clk);
            req = 1'b0;
            if (cfg_pulse) begin cfg_we = 1'b0; cfg_pulse = 0; end
            if (poked) begin req = 1'b0; poked = 0; end
            if ((~cs_n & ~(NZ'(1) << z)) != '0) foreign = 1;
            if (wr ? !rd_n : !wr_n) wrong = 1;
            if (!cs_n[z]) begin
                started = 1; idx++; lastCs = idx;
                if (wr ? !wr_n : !rd_n) nA++;
                else if (nA == 0) nL++;
                else nT++;
            end else if (started) begin
                break;
            end
            if (done) begin nDone++; doneIdx = idx; end
            rdy = (nA >= progA + ws);
            if (mid_cfg && nA == 1 && !cfg_pulse && shadow[z] != newc) begin
                cfg_we = 1'b1; cfg_zone = 2'(z); cfg_wdata = newc;
                cfg_pulse = 1; shadow[z] = newc;
            end
            if (poke && idx == 1) begin
                req = 1'b1; req_zone = 2'((z + 1) % NZ); req_wr = 1'b0; poked = 1;
            end
        end
        rdy = 1'b1; cfg_we = 1'b0; req = 1'b0;
        chk(nL == eL, tag, "lead cycles (R1 R4 R5 R8)", nL, eL);
        chk(nA == eA, tag, "active cycles (R4 R5 R6 R7)", nA, eA);
        chk(nT == eT, tag, "trail cycles (R1 R4 R5 R8)", nT, eT);
        chk(nDone == 1, tag, "done pulses R9", nDone, 1);
        chk(doneIdx == lastCs, tag, "done on final cycle R9", doneIdx, lastCs);
        chk(!foreign, tag, "other zone selected R2", int'(foreign), 0);
        chk(!wrong, tag, "wrong strobe R3", int'(wrong), 0);
        @(negedge clk);
        chk(!busy && cs_n == '1, tag, "idle after access R10",
            int'({busy, cs_n}), int'({1'b0, {NZ{1'b1}}}));
    endtask

    task automatic t_reset();
        chk(cs_n == '1, "R12", "cs_n after reset", int'(cs_n), 15);
        chk(rd_n && wr_n, "R12", "strobes after reset", int'({rd_n, wr_n}), 3);
        chk(!done && !busy, "R12", "done/busy after reset", int'({done, busy}), 0);
    endtask

    task automatic t_basic_read();
        write_cfg(0, mk(0, 2, 3, 1, 5, 5, 5));
        run_access(0, 1'b0, 0, "R4", 1'b0, '0, 1'b0);
    endtask

    task automatic t_write_counts();
        write_cfg(2, mk(0, 6, 6, 6, 1, 0, 3));
        run_access(2, 1'b1, 0, "R3", 1'b0, '0, 1'b0);
    endtask

    task automatic t_doubled();
        write_cfg(1, mk(0, 2, 2, 2, 1, 1, 1));
        set_dbl(1'b1);
        run_access(1, 1'b0, 0, "R5", 1'b0, '0, 1'b0);
        write_cfg(3, mk(1, 1, 1, 1, 1, 1, 1));
        run_access(3, 1'b1, 2, "R5_R6", 1'b0, '0, 1'b0);
        set_dbl(1'b0);
    endtask

    task automatic t_ready();
        write_cfg(3, mk(1, 1, 1, 2, 1, 1, 1));
        run_access(3, 1'b0, 3, "R6", 1'b0, '0, 1'b0);
        run_access(3, 1'b0, 0, "R6", 1'b0, '0, 1'b0);
    endtask

    task automatic t_ready_ignored();
        write_cfg(0, mk(0, 1, 2, 1, 1, 1, 1));
        run_access(0, 1'b0, 4, "R7", 1'b0, '0, 1'b0);
    endtask

    task automatic t_zero_phases();
        write_cfg(1, mk(0, 3, 1, 0, 0, 2, 1));
        run_access(1, 1'b0, 0, "R8", 1'b0, '0, 1'b0);
        run_access(1, 1'b1, 0, "R8", 1'b0, '0, 1'b0);
    endtask

    task automatic t_busy_drop();
        write_cfg(2, mk(0, 3, 1, 2, 1, 1, 1));
        write_cfg(3, mk(0, 1, 1, 1, 1, 1, 1));
        run_access(2, 1'b0, 0, "R10", 1'b0, '0, 1'b1);
        @(negedge clk);
        chk(cs_n == '1 && !busy, "R10", "no access after dropped request",
            int'({busy, cs_n}), 15);
    endtask

    task automatic t_mid_cfg();
        write_cfg(0, mk(0, 1, 2, 1, 1, 1, 1));
        run_access(0, 1'b0, 0, "R11", 1'b1, mk(0, 4, 0, 3, 1, 1, 1), 1'b0);
        run_access(0, 1'b0, 0, "R11_next", 1'b0, '0, 1'b0);
    endtask

    // R13 field order is exercised by every write_cfg through zone_cfg_t packing.
    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int z = 0; z < NZ; z++) shadow[z] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic_read();
        t_write_counts();
        t_doubled();
        t_ready();
        t_ready_ignored();
        t_zero_phases();
        t_busy_drop();
        t_mid_cfg();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule